// File: doc/BRIEF.md
# Bus-Written Four-Digit Segment Latch

This block is the processor-facing write path of a four-digit seven-segment display driver. A bus master presents a 4-bit value and a 2-bit digit address, then pulls two active-low select lines low together. While both selects are low, the value and address are copied into holding registers. When the both-low condition ends, the held value is converted to a seven-segment glyph. The glyph is stored in the output register of the digit that the held address names.

The four digit registers drive the segment outputs directly and keep their glyphs until the next write to the same digit. A static mode input picks one of two glyph sets. The hexadecimal set shows 0 to 9 followed by A to F. The alternate set shows 0 to 9 followed by dash, E, H, L, P and blank. Both selects are sampled in the system clock domain.

Top module: `bus_digit_writer`

## Requirements
- R1: The value on `dataIn` (true binary, bit 0 least significant) and the address on `addrIn` are taken into holding registers on each clock edge at which both `selANeg` and `selBNeg` are low. When only one select is low, or neither is, the holding registers keep their contents.
- R2: A write happens on the first clock edge at which both selects were low at the previous edge and are not both low at this edge. The new glyph is visible on `segOut` right after that edge. `segOut` never changes at an edge where both selects are low.
- R3: Held address 3 (binary 11) writes digit D1 at `segOut[6:0]`. Address 2 writes D2 at `segOut[13:7]`. Address 1 writes D3 at `segOut[20:14]`. Address 0 writes D4 at `segOut[27:21]`.
- R4: With `codeBMode` low, values 0 to 15 give glyphs for 0 to 9, then A, b, C, d, E, F. As hex codes (g down to a) these are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.
- R5: With `codeBMode` high, values 10 to 15 give dash (40), E (79), H (76), L (38), P (73) and blank (00).
- R6: Each both-low interval produces exactly one write to exactly one digit. Raising the remaining low select later causes no further change, whatever the bus then carries.
- R7: While `rstN` is low, all 28 segment bits are 0, which is blank on every digit.
- R8: Within each 7-bit digit field, bit 0 is segment a, and bits 1 to 6 are segments b, c, d, e, f and g in that order. A 1 lights the segment.
- R9: The mode in force at the write edge picks the glyph set. For values 0 to 9 both modes give the same decimal glyphs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dataIn | input | 4 | Value to display, true binary |
| addrIn | input | 2 | Digit address (3 selects D1, 0 selects D4) |
| selANeg | input | 1 | First active-low select |
| selBNeg | input | 1 | Second active-low select |
| codeBMode | input | 1 | 1 = alternate glyph set, 0 = hexadecimal |
| segOut | output | 28 | Four 7-bit digit glyphs, D1 in the low bits |

## Verification
Three things can meet at the same clock edge. The commit of the held value falls on the same edge where the bus master releases a select and drives a new value and address. The bench changes `dataIn` and `addrIn` at the very half-cycle in which the first select rises. It then expects the glyph of the earlier held value at the earlier held digit. A later rise of the second select, made together with fresh bus contents, must leave all 28 bits untouched.

// File: rtl/bdw_pkg.sv
package bdw_pkg;

  localparam int SEG_W = 7;
  localparam int NIB_W = 4;

  typedef struct packed {
    logic capture;
    logic commit;
  } bdw_strobe_t;

  function automatic logic [SEG_W-1:0] hexGlyph(input logic [NIB_W-1:0] v);
    logic [SEG_W-1:0] g;
    case (v)
      4'h0: g = 7'h3F;
      4'h1: g = 7'h06;
      4'h2: g = 7'h5B;
      4'h3: g = 7'h4F;
      4'h4: g = 7'h66;
      4'h5: g = 7'h6D;
      4'h6: g = 7'h7D;
      4'h7: g = 7'h07;
      4'h8: g = 7'h7F;
      4'h9: g = 7'h6F;
      4'hA: g = 7'h77;
      4'hB: g = 7'h7C;
      4'hC: g = 7'h39;
      4'hD: g = 7'h5E;
      4'hE: g = 7'h79;
      default: g = 7'h71;
    endcase
    return g;
  endfunction

  function automatic logic [SEG_W-1:0] altGlyph(input logic [NIB_W-1:0] v);
    logic [SEG_W-1:0] g;
    case (v)
      4'hA: g = 7'h40;
      4'hB: g = 7'h79;
      4'hC: g = 7'h76;
      4'hD: g = 7'h38;
      4'hE: g = 7'h73;
      4'hF: g = 7'h00;
      default: g = hexGlyph(v);
    endcase
    return g;
  endfunction

endpackage

// File: rtl/bdw_ctrl.sv
module bdw_ctrl
  import bdw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        selANeg,
  input  logic        selBNeg,
  output bdw_strobe_t strobe
);

  logic bothLow;
  logic wasBothLow;

  assign bothLow = ~selANeg & ~selBNeg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wasBothLow <= 1'b0;
    else       wasBothLow <= bothLow;
  end

  always_comb begin
    strobe.capture = bothLow;
    strobe.commit  = wasBothLow & ~bothLow;
  end

endmodule

// File: rtl/bdw_decoder.sv
module bdw_decoder
  import bdw_pkg::*;
(
  input  logic [NIB_W-1:0] nibble,
  input  logic             codeBMode,
  output logic [SEG_W-1:0] glyph
);

  always_comb begin
    if (codeBMode) glyph = altGlyph(nibble);
    else           glyph = hexGlyph(nibble);
  end

endmodule

// File: rtl/bdw_datapath.sv
module bdw_datapath
  import bdw_pkg::*;
#(
  parameter int ADDR_W = 2,
  localparam int NUM_DIGITS = 1 << ADDR_W
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  bdw_strobe_t                      strobe,
  input  logic [NIB_W-1:0]                 dataIn,
  input  logic [ADDR_W-1:0]                addrIn,
  input  logic                             codeBMode,
  output logic [NUM_DIGITS-1:0][SEG_W-1:0] digits
);

  logic [NIB_W-1:0]  heldData;
  logic [ADDR_W-1:0] heldAddr;
  logic [SEG_W-1:0]  glyph;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldData <= '0;
      heldAddr <= '0;
    end else if (strobe.capture) begin
      heldData <= dataIn;
      heldAddr <= addrIn;
    end
  end

  bdw_decoder u_decoder (
    .nibble    (heldData),
    .codeBMode (codeBMode),
    .glyph     (glyph)
  );

  // Address counts down from the most significant digit
  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(NUM_DIGITS - 1 - d);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                    digits[d] <= '0;
      else if (strobe.commit && heldAddr == MY_ADDR) digits[d] <= glyph;
    end
  end

endmodule

// File: rtl/bus_digit_writer.sv
module bus_digit_writer
  import bdw_pkg::*;
#(
  parameter int ADDR_W = 2,
  localparam int NUM_DIGITS = 1 << ADDR_W,
  localparam int OUT_W = NUM_DIGITS * SEG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NIB_W-1:0]  dataIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              selANeg,
  input  logic              selBNeg,
  input  logic              codeBMode,
  output logic [OUT_W-1:0]  segOut
);

  bdw_strobe_t                      strobe;
  logic [NUM_DIGITS-1:0][SEG_W-1:0] digits;

  bdw_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .selANeg (selANeg),
    .selBNeg (selBNeg),
    .strobe  (strobe)
  );

  bdw_datapath #(.ADDR_W(ADDR_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .dataIn    (dataIn),
    .addrIn    (addrIn),
    .codeBMode (codeBMode),
    .digits    (digits)
  );

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_out
    assign segOut[d*SEG_W +: SEG_W] = digits[d];
  end

endmodule

// File: rtl/bdw_checker.sv
module bdw_checker
  import bdw_pkg::*;
#(
  parameter int ADDR_W = 2,
  localparam int NUM_DIGITS = 1 << ADDR_W,
  localparam int OUT_W = NUM_DIGITS * SEG_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             selANeg,
  input logic             selBNeg,
  input logic [OUT_W-1:0] segOut
);

  logic                  bothLow;
  logic [OUT_W-1:0]      prevSeg;
  logic [NUM_DIGITS-1:0] diffMask;

  assign bothLow = ~selANeg & ~selBNeg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSeg <= '0;
    else       prevSeg <= segOut;
  end

  always_comb begin
    for (int d = 0; d < NUM_DIGITS; d++)
      diffMask[d] = segOut[d*SEG_W +: SEG_W] != prevSeg[d*SEG_W +: SEG_W];
  end

  // R7
  always @(negedge clk) begin
    if (!rstN) reset_blank_chk: assert (segOut == '0);
  end

  // R2
  hold_while_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    bothLow |=> $stable(segOut));

  // R2
  commit_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(segOut) |-> ($past(bothLow, 2) && !$past(bothLow)));

  // R6
  single_digit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(diffMask) <= 1);

endmodule

bind bus_digit_writer bdw_checker #(.ADDR_W(ADDR_W)) u_bdw_checker (
  .clk     (clk),
  .rstN    (rstN),
  .selANeg (selANeg),
  .selBNeg (selBNeg),
  .segOut  (segOut)
);

// File: tb/tb_bus_digit_writer.sv
module tb_bus_digit_writer;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  dataIn;
  logic [1:0]  addrIn;
  logic        selANeg;
  logic        selBNeg;
  logic        codeBMode;
  logic [27:0] segOut;

  int checkCount = 0;
  int failCount  = 0;
  logic [27:0] model;
  logic [6:0]  hexExp [16];
  logic [6:0]  altExp [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_digit_writer dut (
    .clk       (clk),
    .rstN      (rstN),
    .dataIn    (dataIn),
    .addrIn    (addrIn),
    .selANeg   (selANeg),
    .selBNeg   (selBNeg),
    .codeBMode (codeBMode),
    .segOut    (segOut)
  );

  task automatic check(input string tag, input logic [27:0] act, input logic [27:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R3: address a lands in digit index 3-a
  function automatic int slotOf(input logic [1:0] a);
    return 3 - int'(a);
  endfunction

  function automatic logic [6:0] expGlyph(input logic [3:0] v);
    return codeBMode ? altExp[v] : hexExp[v];
  endfunction

  task automatic lowerBoth(input logic [1:0] a, input logic [3:0] v);
    @(negedge clk);
    addrIn = a; dataIn = v; selANeg = 1'b0; selBNeg = 1'b0;
  endtask

  task automatic raiseSel(input bit ra, input bit rb);
    @(negedge clk);
    if (ra) selANeg = 1'b1;
    if (rb) selBNeg = 1'b1;
  endtask

  task automatic fullWrite(input logic [1:0] a, input logic [3:0] v);
    lowerBoth(a, v);
    raiseSel(1, 1);
    model[slotOf(a)*7 +: 7] = expGlyph(v);
    @(negedge clk);
  endtask

  task automatic testReset;
    @(negedge clk);
    check("R7 reset blank", segOut, 28'h0);
  endtask

  task automatic testHexTable;
    codeBMode = 1'b0;
    for (int v = 0; v < 16; v++) begin
      fullWrite(2'(v), 4'(v));
      check($sformatf("R4 R8 hex value %0d", v), segOut, model);
    end
  endtask

  task automatic testAltTable;
    codeBMode = 1'b1;
    for (int v = 0; v < 16; v++) begin
      fullWrite(2'(v), 4'(v));
      check($sformatf("R5 alt value %0d", v), segOut, model);
    end
  endtask

  task automatic testAddressMap;
    codeBMode = 1'b0;
    fullWrite(2'd0, 4'd1);
    fullWrite(2'd1, 4'd2);
    fullWrite(2'd2, 4'd3);
    fullWrite(2'd3, 4'd4);
    check("R3 D4 field", {21'h0, segOut[27:21]}, {21'h0, 7'h06});
    check("R3 D3 field", {21'h0, segOut[20:14]}, {21'h0, 7'h5B});
    check("R3 D2 field", {21'h0, segOut[13:7]},  {21'h0, 7'h4F});
    check("R3 D1 field", {21'h0, segOut[6:0]},   {21'h0, 7'h66});
  endtask

  task automatic testCaptureOnlyBothLow;
    codeBMode = 1'b0;
    @(negedge clk);
    addrIn = 2'd3; dataIn = 4'd8; selANeg = 1'b0;
    @(negedge clk);
    dataIn = 4'd2;
    @(negedge clk);
    check("R1 single select no write", segOut, model);
    selBNeg = 1'b0;
    @(negedge clk);
    check("R2 no change while both low", segOut, model);
    selANeg = 1'b1; dataIn = 4'd7; addrIn = 2'd0;
    model[slotOf(2'd3)*7 +: 7] = expGlyph(4'd2);
    @(negedge clk);
    check("R1 held value committed, not new bus", segOut, model);
    selBNeg = 1'b1;
    @(negedge clk);
    check("R6 second rise no write", segOut, model);
  endtask

  task automatic testLongLow;
    codeBMode = 1'b1;
    lowerBoth(2'd0, 4'd5);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check($sformatf("R2 stable in long low %0d", i), segOut, model);
      addrIn = 2'(i + 1); dataIn = 4'(10 + i);
    end
    raiseSel(1, 1);
    model[slotOf(2'd0)*7 +: 7] = expGlyph(4'd13);
    @(negedge clk);
    check("R2 R6 last captured written once", segOut, model);
  endtask

  task automatic testLateSecondRise;
    codeBMode = 1'b0;
    lowerBoth(2'd2, 4'd9);
    raiseSel(0, 1);
    model[slotOf(2'd2)*7 +: 7] = expGlyph(4'd9);
    @(negedge clk);
    check("R6 first rise commits", segOut, model);
    dataIn = 4'd0; addrIn = 2'd1;
    repeat (3) @(negedge clk);
    selANeg = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R6 late rise ignored", segOut, model);
  endtask

  task automatic testBcdBothModes;
    logic [6:0] hexSide;
    for (int v = 0; v < 10; v++) begin
      codeBMode = 1'b0;
      fullWrite(2'd3, 4'(v));
      hexSide = segOut[6:0];
      codeBMode = 1'b1;
      fullWrite(2'd3, 4'(v));
      check($sformatf("R9 decimal %0d same in both modes", v),
            {21'h0, segOut[6:0]}, {21'h0, hexSide});
      check($sformatf("R9 decimal %0d glyph", v),
            {21'h0, segOut[6:0]}, {21'h0, hexExp[v]});
    end
  endtask

  initial begin
    hexExp = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
               7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    altExp = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
               7'h7F, 7'h6F, 7'h40, 7'h79, 7'h76, 7'h38, 7'h73, 7'h00};
    model = '0;
    rstN = 1'b0; selANeg = 1'b1; selBNeg = 1'b1;
    dataIn = '0; addrIn = '0; codeBMode = 1'b0;
    testReset();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    testHexTable();
    testAltTable();
    testAddressMap();
    testCaptureOnlyBothLow();
    testLongLow();
    testLateSecondRise();
    testBcdBothModes();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

endmodule